// File: doc/BRIEF.md
# UART Sleep and Wake Controller

This block decides when a serial port may stop its oscillator and when it must start it again. Each cycle it looks at the port's idle state: no interrupt pending, sleep allowed, modem lines quiet, baud divisor set, both FIFOs drained and the receive line at rest. When all of these hold it raises an oscillator-stop control. The receive line is at rest when it is high in normal mode and low in infrared mode.

While asleep, three kinds of event restart the clock: a falling edge on the receive pin, a host write to the transmitter, or a level change on any of the four modem inputs. The receive pin and the modem inputs pass through synchronizers before edge detection. When the power-save pin is high, the controller also isolates the host bus while asleep. In that state a transmitter write cannot wake the port. An optional wake interrupt flags each wake-up until the host acknowledges it.

After a wake-up the block goes back to sleep by itself once the idle state holds again. A wake caused by a modem input also needs a modem-status read first. Clearing the sleep enable leaves sleep and disarms the feature.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: When every entry condition holds (no pending interrupt, sleep enable 1, all four modem delta bits 0, divisor nonzero, both FIFOs empty, receive line idle) and no wake interrupt or modem hold is outstanding, `oscStop` rises within a few cycles and stays high.
- R2: If any single entry condition is false, `oscStop` stays low.
- R3: The receive line counts as idle when it is high with `irMode` 0, and when it is low with `irMode` 1.
- R4: While asleep, a high-to-low transition on `rxPin` clears `oscStop` within four cycles, whatever the level of `pwrSavePin`.
- R5: While asleep, a level change on any bit of `modemIn` (bit 0 CTS, 1 DSR, 2 CD, 3 RI) clears `oscStop` within four cycles.
- R6: While asleep with `pwrSavePin` low, a one-cycle `txWrite` clears `oscStop` on the next clock edge.
- R7: `busIsolate` is high exactly while asleep with `pwrSavePin` high and `sleepEn` high. In that state `txWrite` does not wake the port.
- R8: Driving `pwrSavePin` low drops `busIsolate` and keeps the port asleep. Clearing `sleepEn` drops both `busIsolate` and `oscStop` on the next edge.
- R9: `wakeIrq` is low after reset. It rises on a wake-up only when `wakeIntEn` is 1, and it falls on the edge after a `wakeAck` pulse.
- R10: After a wake caused by a modem input, sleep is not re-entered until a one-cycle `msrRead` pulse has been seen.
- R11: After a wake-up, the port returns to sleep by itself once all entry conditions hold again.
- R12: An unacknowledged `wakeIrq` counts as a pending interrupt and blocks sleep entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| intPending | input | 1 | Some interrupt of the port is pending |
| sleepEn | input | 1 | Sleep feature armed |
| modemDelta | input | 4 | Modem status change flags |
| rxPin | input | 1 | Raw receive pin |
| irMode | input | 1 | Infrared coding active, so receive idles low |
| divNonZero | input | 1 | Baud divisor is nonzero |
| txFifoEmpty | input | 1 | Transmit FIFO empty |
| rxFifoEmpty | input | 1 | Receive FIFO empty |
| txWrite | input | 1 | Host write to the transmitter (one-cycle strobe) |
| modemIn | input | 4 | Raw modem inputs: CTS, DSR, CD, RI in bits 0 to 3 |
| pwrSavePin | input | 1 | Power-save strap |
| wakeIntEn | input | 1 | Wake interrupt enable |
| wakeAck | input | 1 | Host acknowledge of the wake interrupt |
| msrRead | input | 1 | Host read of the modem status register |
| oscStop | output | 1 | Stop the oscillator (asleep) |
| busIsolate | output | 1 | Isolate the host bus |
| wakeIrq | output | 1 | Wake interrupt |

## Verification
A wrong sleep state shows at once on `oscStop`. It can appear as an entry with one condition false, a missed wake, or no return to sleep after the interrupt is serviced. It shows within the synchronizer delay of the event, at most four cycles after the pin moves. A stuck modem hold or stuck wake interrupt shows as a port that never sleeps again. A cleared modem hold shows as a port that sleeps again before the modem-status read. In either case the error is visible a few cycles after the releasing or blocking event. A wrong isolation term shows on `busIsolate` in the cycle after the power-save pin or the sleep enable moves.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;
  // datapath -> control: qualified events and the entry verdict
  typedef struct packed {
    logic rxFall;
    logic modemChg;
    logic canSleep;
  } sleepEvt_t;

  // control -> datapath: strobes for the sticky wake state
  typedef struct packed {
    logic wakeUp;
    logic modemWake;
  } sleepStrb_t;
endpackage

// File: rtl/usc_datapath.sv
module usc_datapath
  import uart_sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_MODEM   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 intPending,
  input  logic                 sleepEn,
  input  logic [NUM_MODEM-1:0] modemDelta,
  input  logic                 rxPin,
  input  logic                 irMode,
  input  logic                 divNonZero,
  input  logic                 txFifoEmpty,
  input  logic                 rxFifoEmpty,
  input  logic [NUM_MODEM-1:0] modemIn,
  input  logic                 wakeIntEn,
  input  logic                 wakeAck,
  input  logic                 msrRead,
  input  sleepStrb_t           strb,
  output sleepEvt_t            evt,
  output logic                 wakeIrq
);
  localparam int W         = NUM_MODEM + 1;
  localparam int PRIME_MAX = SYNC_STAGES + 1;
  localparam int PW        = $clog2(PRIME_MAX + 1);

  logic [SYNC_STAGES-1:0][W-1:0] syncQ;
  logic [W-1:0] prevQ;
  logic [W-1:0] settled;
  logic [PW-1:0] primeCnt;
  logic primed;
  logic modemHold;
  logic wakeIrqQ;
  logic rxNow;
  logic rxIdle;

  assign settled = syncQ[SYNC_STAGES-1];
  assign primed  = (primeCnt == PW'(PRIME_MAX));
  assign rxNow   = settled[0];

  // synchronizer chain for {modemIn, rxPin} plus one history stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ    <= '0;
      prevQ    <= '0;
      primeCnt <= '0;
    end else begin
      syncQ[0] <= {modemIn, rxPin};
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= settled;
      if (!primed) primeCnt <= primeCnt + 1'b1;
    end
  end

  // edges count only once the chain holds real pin history
  assign evt.rxFall   = primed & prevQ[0] & ~rxNow;
  assign evt.modemChg = primed & (settled[W-1:1] != prevQ[W-1:1]);

  assign rxIdle = irMode ? ~rxNow : rxNow;

  assign evt.canSleep = primed & ~intPending & sleepEn & ~|modemDelta &
                        divNonZero & txFifoEmpty & rxFifoEmpty & rxIdle &
                        ~modemHold & ~wakeIrqQ;

  // sticky wake state: set by control strobes, cleared by host actions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modemHold <= 1'b0;
      wakeIrqQ  <= 1'b0;
    end else begin
      if (strb.modemWake)  modemHold <= 1'b1;
      else if (msrRead)    modemHold <= 1'b0;
      if (strb.wakeUp && wakeIntEn) wakeIrqQ <= 1'b1;
      else if (wakeAck)             wakeIrqQ <= 1'b0;
    end
  end

  assign wakeIrq = wakeIrqQ;
endmodule

// File: rtl/usc_control.sv
module usc_control
  import uart_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sleepEvt_t  evt,
  input  logic       sleepEn,
  input  logic       pwrSavePin,
  input  logic       txWrite,
  output sleepStrb_t strb,
  output logic       oscStop,
  output logic       busIsolate
);
  logic asleepQ;
  logic wakeSrc;

  // with the bus isolated, host writes are not a wake source
  assign wakeSrc = evt.rxFall | evt.modemChg | (txWrite & ~pwrSavePin);

  assign strb.wakeUp    = asleepQ & sleepEn & wakeSrc;
  assign strb.modemWake = asleepQ & sleepEn & evt.modemChg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleepQ <= 1'b0;
    end else if (asleepQ) begin
      if (!sleepEn || wakeSrc) asleepQ <= 1'b0;
    end else if (evt.canSleep) begin
      asleepQ <= 1'b1;
    end
  end

  assign oscStop    = asleepQ;
  assign busIsolate = asleepQ & pwrSavePin & sleepEn;
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
  import uart_sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_MODEM   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 intPending,
  input  logic                 sleepEn,
  input  logic [NUM_MODEM-1:0] modemDelta,
  input  logic                 rxPin,
  input  logic                 irMode,
  input  logic                 divNonZero,
  input  logic                 txFifoEmpty,
  input  logic                 rxFifoEmpty,
  input  logic                 txWrite,
  input  logic [NUM_MODEM-1:0] modemIn,
  input  logic                 pwrSavePin,
  input  logic                 wakeIntEn,
  input  logic                 wakeAck,
  input  logic                 msrRead,
  output logic                 oscStop,
  output logic                 busIsolate,
  output logic                 wakeIrq
);
  sleepEvt_t  evt;
  sleepStrb_t strb;

  usc_datapath #(.SYNC_STAGES(SYNC_STAGES), .NUM_MODEM(NUM_MODEM)) u_dp (
    .clk(clk), .rst_n(rst_n), .intPending(intPending), .sleepEn(sleepEn),
    .modemDelta(modemDelta), .rxPin(rxPin), .irMode(irMode),
    .divNonZero(divNonZero), .txFifoEmpty(txFifoEmpty),
    .rxFifoEmpty(rxFifoEmpty), .modemIn(modemIn), .wakeIntEn(wakeIntEn),
    .wakeAck(wakeAck), .msrRead(msrRead), .strb(strb), .evt(evt),
    .wakeIrq(wakeIrq)
  );

  usc_control u_ctl (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sleepEn(sleepEn),
    .pwrSavePin(pwrSavePin), .txWrite(txWrite), .strb(strb),
    .oscStop(oscStop), .busIsolate(busIsolate)
  );
endmodule

// File: rtl/usc_checker.sv
module usc_checker #(
  parameter int NUM_MODEM = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 intPending,
  input logic                 sleepEn,
  input logic                 txWrite,
  input logic                 pwrSavePin,
  input logic                 wakeIntEn,
  input logic                 wakeAck,
  input logic                 oscStop,
  input logic                 busIsolate,
  input logic                 wakeIrq
);
  // R2, R12: no entry while an interrupt is pending
  p_no_entry_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!oscStop && (intPending || wakeIrq)) |=> !oscStop);

  // R2: no entry while disarmed
  p_no_entry_disarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!oscStop && !sleepEn) |=> !oscStop);

  // R6: transmitter write wakes outside power-save
  p_tx_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oscStop && sleepEn && !pwrSavePin && txWrite) |=> !oscStop);

  // R7: isolation only while asleep, strapped and armed
  p_iso_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busIsolate |-> (oscStop && pwrSavePin && sleepEn));

  // R8: disarming ends sleep on the next edge
  p_disarm_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oscStop && !sleepEn) |=> !oscStop);

  // R9: no wake interrupt without its enable
  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wakeIrq && !wakeIntEn) |=> !wakeIrq);

  // R9: acknowledge clears the interrupt while awake
  p_irq_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeIrq && wakeAck && !oscStop) |=> !wakeIrq);
endmodule

bind uart_sleep_ctrl usc_checker #(.NUM_MODEM(NUM_MODEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .intPending(intPending), .sleepEn(sleepEn),
  .txWrite(txWrite), .pwrSavePin(pwrSavePin), .wakeIntEn(wakeIntEn),
  .wakeAck(wakeAck), .oscStop(oscStop), .busIsolate(busIsolate),
  .wakeIrq(wakeIrq)
);

// File: tb/tb_uart_sleep_ctrl.sv
module tb_uart_sleep_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic intPending, sleepEn, rxPin, irMode, divNonZero;
  logic txFifoEmpty, rxFifoEmpty, txWrite, pwrSavePin;
  logic wakeIntEn, wakeAck, msrRead;
  logic [3:0] modemDelta, modemIn;
  logic oscStop, busIsolate, wakeIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_sleep_ctrl dut (
    .clk(clk), .rst_n(rst_n), .intPending(intPending), .sleepEn(sleepEn),
    .modemDelta(modemDelta), .rxPin(rxPin), .irMode(irMode),
    .divNonZero(divNonZero), .txFifoEmpty(txFifoEmpty),
    .rxFifoEmpty(rxFifoEmpty), .txWrite(txWrite), .modemIn(modemIn),
    .pwrSavePin(pwrSavePin), .wakeIntEn(wakeIntEn), .wakeAck(wakeAck),
    .msrRead(msrRead), .oscStop(oscStop), .busIsolate(busIsolate),
    .wakeIrq(wakeIrq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expectSleep(logic ip, logic en, logic [3:0] dl,
                                       logic dv, logic te, logic re,
                                       logic rx, logic ir);
    return !ip && en && (dl == 4'd0) && dv && te && re && (ir ? !rx : rx);
  endfunction

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    intPending = 0; sleepEn = 1; modemDelta = 0; rxPin = 1; irMode = 0;
    divNonZero = 1; txFifoEmpty = 1; rxFifoEmpty = 1; txWrite = 0;
    modemIn = 4'b0101; pwrSavePin = 0; wakeIntEn = 1; wakeAck = 0; msrRead = 0;
    tick(3);
    check("R9 reset wakeIrq", wakeIrq, 1'b0);
    check("R1 reset oscStop", oscStop, 1'b0);
    check("R7 reset busIsolate", busIsolate, 1'b0);
    rst_n = 1'b1;
    tick(8);
    check("R1 entry", oscStop, 1'b1);

    // R6 / R9 / R12 / R11
    txWrite = 1; tick(1); txWrite = 0;
    check("R6 tx wake", oscStop, 1'b0);
    check("R9 irq raised", wakeIrq, 1'b1);
    tick(4);
    check("R12 irq blocks entry", oscStop, 1'b0);
    wakeAck = 1; tick(1); wakeAck = 0;
    check("R9 ack clears", wakeIrq, 1'b0);
    tick(3);
    check("R11 auto re-entry", oscStop, 1'b1);

    // R7 power-save
    wakeIntEn = 0; pwrSavePin = 1; tick(1);
    check("R7 isolate on", busIsolate, 1'b1);
    txWrite = 1; tick(1); txWrite = 0; tick(3);
    check("R7 tx ignored", oscStop, 1'b1);

    // R4 rx fall in power-save
    rxPin = 0; tick(4);
    check("R4 rx fall wakes", oscStop, 1'b0);
    check("R7 isolate off awake", busIsolate, 1'b0);
    check("R9 no irq when disabled", wakeIrq, 1'b0);
    rxPin = 1; tick(6);
    check("R11 re-entry after rx", oscStop, 1'b1);

    // R8
    pwrSavePin = 0; tick(1);
    check("R8 pin low isolate", busIsolate, 1'b0);
    check("R8 pin low still asleep", oscStop, 1'b1);
    pwrSavePin = 1; tick(1);
    sleepEn = 0; tick(1);
    check("R8 disarm wakes", oscStop, 1'b0);
    check("R8 disarm isolate", busIsolate, 1'b0);
    sleepEn = 1; pwrSavePin = 0; tick(3);
    check("R1 re-armed entry", oscStop, 1'b1);

    // R5 / R10 modem wake
    modemIn[2] = ~modemIn[2]; tick(4);
    check("R5 modem wake", oscStop, 1'b0);
    tick(6);
    check("R10 hold until msr read", oscStop, 1'b0);
    msrRead = 1; tick(1); msrRead = 0; tick(3);
    check("R10 sleep after msr read", oscStop, 1'b1);

    // R3 infrared idle level
    sleepEn = 0; irMode = 1; rxPin = 1; tick(4);
    sleepEn = 1; tick(5);
    check("R3 ir high not idle", oscStop, 1'b0);
    rxPin = 0; tick(5);
    check("R3 ir low idle", oscStop, 1'b1);
    sleepEn = 0; irMode = 0; rxPin = 1; tick(4);

    // R2 constrained random entry conditions
    for (int i = 0; i < 60; i++) begin
      logic enNext;
      sleepEn = 0;
      intPending  = ($urandom % 5) == 0;
      modemDelta  = (($urandom % 5) == 0) ? 4'(1 << ($urandom % 4)) : 4'd0;
      divNonZero  = ($urandom % 5) != 0;
      txFifoEmpty = ($urandom % 5) != 0;
      rxFifoEmpty = ($urandom % 5) != 0;
      irMode      = $urandom % 2;
      rxPin       = $urandom % 2;
      enNext      = ($urandom % 5) != 0;
      tick(4);
      sleepEn = enNext;
      tick(3);
      check("R2 random entry", oscStop,
            expectSleep(intPending, sleepEn, modemDelta, divNonZero,
                        txFifoEmpty, rxFifoEmpty, rxPin, irMode));
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule